// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider Controller

This block sits behind an external two-modulus prescaler (divide by N or N+1) in a frequency synthesiser. It runs on the prescaler output, which is its only clock. With two counters it turns that clock into one pulse per comparison period for a phase detector. A 4-bit swallow counter holds the prescaler at N+1 for the first A prescaler periods of each cycle. A 15-bit main counter ends the cycle after M prescaler periods. The input is therefore divided by M·N + A overall. Stepping A by one moves the synthesised frequency by one comparison-rate step.

The programmed A and M values and the narrow/wide prescaler selection (8/9 or 16/17) are plain level inputs. The block samples them only at a cycle boundary, so software may rewrite them at any time without corrupting a count in progress. No data stream passes through the block, so it has no valid/ready handshake. All pins are plain control and status levels. A configuration flag reports settings that cannot give the intended ratio.

Top module: `swallow_div_ctrl`

## Requirements
- R1: In the first clock of every cycle, `mod_n1` is 1 whenever the active A is non-zero. Encoding: `mod_n1` = 1 requests divide by N+1, and 0 requests divide by N.
- R2: Within a cycle, `mod_n1` is 1 for exactly the first min(A, M) clocks and 0 for the rest of that cycle.
- R3: For M ≥ 1, `div_pulse` is high for exactly one clock, and it repeats every M clocks. It marks the first clock of each cycle.
- R4: Summed over one cycle, the prescaler input periods (N+1 while `mod_n1` = 1, otherwise N) equal M·N + A whenever M ≥ A. N is 16 when `n16_sel` = 1 and 8 otherwise. This includes 56 (N=8, A=0, M=7) and 524287 (N=16, A=15, M=32767).
- R5: `a_val`, `m_val` and `n16_mode` are captured only on the edge that starts a new cycle, and while reset is held. Changes made at any other time have no effect on the running cycle. `n16_sel` shows the captured mode and stays constant for the whole cycle.
- R6: `cfg_err` is 1 for every clock of a cycle whose captured settings have M < A, or have `n16_sel` = 0 together with A bit 3 = 1. Otherwise `cfg_err` is 0.
- R7: While `rst` is sampled high, `div_pulse` is 0 and both counters are cleared. After release, the first `div_pulse` appears M clocks later.
- R8: With M = 1, every cycle is one clock long, so `div_pulse` stays high on every clock. `mod_n1` is then 1 only when A ≥ 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst | input | 1 | Synchronous reset, active high |
| a_val | input | 4 | Programmed swallow count A |
| m_val | input | 15 | Programmed main count M |
| n16_mode | input | 1 | 1 = 16/17 prescaler, 0 = 8/9 prescaler |
| mod_n1 | output | 1 | Modulus request to the prescaler, 1 = N+1 |
| n16_sel | output | 1 | Prescaler width in use for the current cycle |
| div_pulse | output | 1 | One-clock divided output for the phase detector |
| cfg_err | output | 1 | Settings of the current cycle are unusable |

## Verification
The hardest case to reach from the ports is a settings change that lands inside a running cycle and is then withdrawn before the boundary. Nothing at the outputs shows whether the transient was latched. The stimulus sets a long cycle (M = 40), and five clocks after a boundary it drives unrelated A, M and mode values for four clocks, then restores the settings. The scoreboard requires that cycle's length, its swallow count and its summed ratio to match the restored settings exactly. Separate cases cover M = 1 (a pulse on every clock), both extreme ratios, and both error conditions.

// File: rtl/swl_pkg.sv
package swl_pkg;
  localparam int SWL_A_W = 4;
  localparam int SWL_M_W = 15;

  typedef enum logic {
    MOD_DIV_N  = 1'b0,
    MOD_DIV_N1 = 1'b1
  } mod_sel_e;
endpackage

// File: rtl/swl_cfg_shadow.sv
module swl_cfg_shadow #(
  parameter int AW = 4,
  parameter int MW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] a_in,
  input  logic [MW-1:0] m_in,
  input  logic          n16_in,
  output logic [AW-1:0] a_cur,
  output logic [MW-1:0] m_cur,
  output logic          n16_cur,
  output logic          err_cur
);
  localparam int CW = AW + MW;

  logic [CW-1:0] m_ext;
  logic [CW-1:0] a_ext;
  logic          err_nxt;

  // Error is judged on the incoming settings so it is ready with them.
  always_comb begin
    m_ext   = {{AW{1'b0}}, m_in};
    a_ext   = {{MW{1'b0}}, a_in};
    err_nxt = (m_ext < a_ext) || (!n16_in && a_in[AW-1]);
  end

  always_ff @(posedge clk) begin
    if (rst || load) begin
      a_cur   <= a_in;
      m_cur   <= m_in;
      n16_cur <= n16_in;
      err_cur <= err_nxt;
    end
  end
endmodule

// File: rtl/swl_main_cnt.sv
module swl_main_cnt #(
  parameter int MW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [MW-1:0] m_cur,
  output logic          term,
  output logic          div_pulse
);
  logic [MW-1:0] cnt;
  logic [MW:0]   cnt_inc;

  always_comb begin
    cnt_inc = {1'b0, cnt} + {{MW{1'b0}}, 1'b1};
    // Last slot of the cycle; M of 0 or 1 both give a one-slot cycle.
    term    = (cnt_inc >= {1'b0, m_cur});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      div_pulse <= 1'b0;
    end else if (term) begin
      cnt       <= '0;
      div_pulse <= 1'b1;
    end else begin
      cnt       <= cnt_inc[MW-1:0];
      div_pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/swl_swallow_cnt.sv
module swl_swallow_cnt
  import swl_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [AW-1:0] a_cur,
  output mod_sel_e      mod_sel
);
  logic [AW-1:0] cnt;
  logic          reached;

  always_comb begin
    reached = (cnt == a_cur);
    mod_sel = reached ? MOD_DIV_N : MOD_DIV_N1;
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (!reached) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/swallow_div_ctrl.sv
module swallow_div_ctrl
  import swl_pkg::*;
#(
  parameter int A_W = SWL_A_W,
  parameter int M_W = SWL_M_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [A_W-1:0] a_val,
  input  logic [M_W-1:0] m_val,
  input  logic           n16_mode,
  output logic           mod_n1,
  output logic           n16_sel,
  output logic           div_pulse,
  output logic           cfg_err
);
  logic [A_W-1:0] a_cur;
  logic [M_W-1:0] m_cur;
  logic           term;
  mod_sel_e       mod_sel;

  swl_cfg_shadow #(.AW(A_W), .MW(M_W)) u_shadow (
    .clk     (clk),
    .rst     (rst),
    .load    (term),
    .a_in    (a_val),
    .m_in    (m_val),
    .n16_in  (n16_mode),
    .a_cur   (a_cur),
    .m_cur   (m_cur),
    .n16_cur (n16_sel),
    .err_cur (cfg_err)
  );

  swl_main_cnt #(.MW(M_W)) u_main (
    .clk       (clk),
    .rst       (rst),
    .m_cur     (m_cur),
    .term      (term),
    .div_pulse (div_pulse)
  );

  swl_swallow_cnt #(.AW(A_W)) u_swallow (
    .clk     (clk),
    .rst     (rst),
    .restart (term),
    .a_cur   (a_cur),
    .mod_sel (mod_sel)
  );

  assign mod_n1 = (mod_sel == MOD_DIV_N1);
endmodule

// File: rtl/swl_checker.sv
module swl_checker #(
  parameter int AW = 4,
  parameter int MW = 15
) (
  input logic          clk,
  input logic          rst,
  input logic          mod_n1,
  input logic          div_pulse,
  input logic          cfg_err,
  input logic          n16_sel,
  input logic [AW-1:0] a_cur,
  input logic [MW-1:0] m_cur
);
  logic          armed;
  logic [MW-1:0] slot_q;
  logic [MW-1:0] slot_idx;

  always_comb slot_idx = div_pulse ? '0 : slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      slot_q <= '0;
    end else begin
      armed  <= 1'b1;
      slot_q <= slot_idx + 1'b1;
    end
  end

  // R1
  a_r1_start_wide: assert property (@(posedge clk) disable iff (rst)
    (div_pulse && (a_cur != '0)) |-> mod_n1);

  // R2
  a_r2_no_return_high: assert property (@(posedge clk) disable iff (rst)
    !mod_n1 |=> (!mod_n1 || div_pulse));

  // R3
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (div_pulse && (m_cur > 1)) |=> !div_pulse);

  // R3
  a_r3_period_end: assert property (@(posedge clk) disable iff (rst)
    (({1'b0, slot_idx} + 1'b1) == {1'b0, m_cur}) |=> div_pulse);

  // R5
  a_r5_settings_hold: assert property (@(posedge clk) disable iff (rst || !armed)
    !div_pulse |-> ($stable(a_cur) && $stable(m_cur) && $stable(n16_sel)));

  // R6
  a_r6_err_steady: assert property (@(posedge clk) disable iff (rst || !armed)
    !div_pulse |-> $stable(cfg_err));
endmodule

bind swallow_div_ctrl swl_checker #(.AW(A_W), .MW(M_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mod_n1    (mod_n1),
  .div_pulse (div_pulse),
  .cfg_err   (cfg_err),
  .n16_sel   (n16_sel),
  .a_cur     (a_cur),
  .m_cur     (m_cur)
);

// File: tb/test_swallow_div_ctrl.sv
`timescale 1ns/1ps
module test_swallow_div_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  a_val;
  logic [14:0] m_val;
  logic        n16_mode;
  logic        mod_n1, n16_sel, div_pulse, cfg_err;

  typedef struct {
    int a;
    int m;
    bit n16;
  } exp_t;

  exp_t q[$];
  int   tests = 0;
  int   fails = 0;
  bit   done  = 1'b0;

  always #2 clk = ~clk;

  swallow_div_ctrl i_swallow_div_ctrl (
    .clk(clk), .rst(rst), .a_val(a_val), .m_val(m_val), .n16_mode(n16_mode),
    .mod_n1(mod_n1), .n16_sel(n16_sel), .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!div_pulse);
  endtask

  task automatic run_cfg(input int a, input int m, input bit n16, input int reps, input bit glitch);
    a_val = a[3:0]; m_val = m[14:0]; n16_mode = n16;
    for (int r = 0; r < reps; r++) begin
      wait_pulse();
      q.push_back('{a, m, n16});
      if (glitch && r == 0) begin
        // R5: transient settings inside a running cycle, withdrawn in time
        repeat (5) @(negedge clk);
        a_val = 4'd2; m_val = 15'd3; n16_mode = !n16;
        repeat (4) @(negedge clk);
        a_val = a[3:0]; m_val = m[14:0]; n16_mode = n16;
      end
    end
  endtask

  // Monitor: measures each completed cycle and compares with the queue head.
  int len, a_seen, ratio, n_now;
  bit seen_low, bad_order, err0, n16_0, started;

  task automatic close_cycle();
    exp_t e;
    int   ea, n;
    bit   eerr;
    if (q.size() == 0) begin
      chk("R3", "unexpected cycle", 1, 0);
      return;
    end
    e    = q.pop_front();
    ea   = (e.a < e.m) ? e.a : e.m;
    n    = e.n16 ? 16 : 8;
    eerr = (e.m < e.a) || (!e.n16 && e.a >= 8);
    chk("R3", "cycle length", len, e.m);
    chk("R2", "wide slots", a_seen, ea);
    chk("R2", "wide slots leading", int'(bad_order), 0);
    chk("R4", "input periods per cycle", ratio, e.m * n + ea);
    chk("R5", "n16_sel", int'(n16_0), int'(e.n16));
    chk("R6", "cfg_err", int'(err0), int'(eerr));
    if (e.a > 0) chk("R1", "first slot wide", int'(first_wide), 1);
  endtask

  bit first_wide;

  initial begin
    started = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (div_pulse) begin
          if (started) close_cycle();
          started = 1'b1; len = 0; a_seen = 0; ratio = 0;
          seen_low = 1'b0; bad_order = 1'b0;
          err0 = cfg_err; n16_0 = n16_sel; first_wide = mod_n1;
        end
        if (started) begin
          n_now = n16_sel ? 16 : 8;
          len++;
          if (mod_n1) begin
            a_seen++;
            ratio += n_now + 1;
            if (seen_low) bad_order = 1'b1;
          end else begin
            ratio += n_now;
            seen_low = 1'b1;
          end
          if (cfg_err != err0) chk("R6", "cfg_err steady", int'(cfg_err), int'(err0));
        end
      end
    end
  end

  initial begin
    int k;
    rst = 1'b1; a_val = 4'd5; m_val = 15'd20; n16_mode = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7", "div_pulse in reset", int'(div_pulse), 0);
    chk("R7", "mod_n1 in reset", int'(mod_n1), 1);
    rst = 1'b0;
    k = 0;
    do begin @(negedge clk); k++; end while (!div_pulse);
    chk("R7", "clocks to first pulse", k, 20);
    q.push_back('{5, 20, 1'b1});
    run_cfg(5, 20, 1'b1, 2, 1'b0);
    run_cfg(0, 7, 1'b0, 2, 1'b0);       // R4 ratio 56
    run_cfg(7, 7, 1'b0, 2, 1'b0);       // R2 all slots wide
    run_cfg(15, 40, 1'b1, 2, 1'b1);     // R5 glitch
    run_cfg(9, 20, 1'b0, 2, 1'b0);      // R6 A bit 3 in narrow mode
    run_cfg(6, 4, 1'b1, 2, 1'b0);       // R6 M < A
    run_cfg(0, 1, 1'b1, 3, 1'b0);       // R8
    run_cfg(1, 1, 1'b1, 3, 1'b0);       // R8
    run_cfg(15, 32767, 1'b1, 1, 1'b0);  // R4 ratio 524287
    wait_pulse();
    @(negedge clk);
    chk("R3", "items left over", q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule